// File: doc/BRIEF.md
# Translation Unit Control and Fault Register Block

This block is the software-visible control face of an address translation unit. A simple register bus writes and reads a small set of word registers. Through them, software switches the unit between disabled, running and held (blocked) modes, sets its configuration and table base, and requests translation-cache flushes. Software also inspects and acknowledges faults. When a hold is requested, the block tells the datapath to stop issuing traffic. Once the datapath reports that nothing is outstanding, the block confirms the hold through a status bit.

The translation datapath reports faults on a valid/ready stream that carries a 3-bit type code and the faulting address. The stream holds `flt_ready` low while the unit is disabled, so the source must hold or drop the fault itself. In the running and held modes `flt_ready` is high and one fault is taken per cycle. A taken fault latches a per-type pending bit, stores the address in the capture register for its channel, raises the interrupt and forces the unit into the held mode. The unit stays held until software clears every pending bit and writes the run code again.

Top module: `mmuctl_top`

## Requirements
- R1: After reset the control word reads 0x0, the status and interrupt-pending words read 0, `irq_o`, `blocked_o`, `running_o` and `flt_ready` are 0.
- R2: Writing exactly 0x5 to offset 0x00 selects running, 0x7 selects held, 0x0 selects disabled; any other value leaves the mode unchanged. Offset 0x00 reads back 0x5, 0x7 or 0x0 for the current mode, and `running_o` is 1 only in running mode with nothing pending.
- R3: Status bit 0 (offset 0x08) becomes 1 at the first clock edge that follows the edge where `blocked_o` rose and at which `idle_i` is 1. It stays 0 while `idle_i` is 0, and drops in the same cycle as `blocked_o`.
- R4: `flt_ready` is 1 exactly when the mode is not disabled. A taken fault of type t sets bit t of the pending word at offset 0x18. The bit order from bit 0 up is: page fault, read multi-hit, write multi-hit, bus error, read security, read access, write security, write access. A fault offered while the unit is disabled sets nothing. `irq_o` is the OR of the pending bits.
- R5: Writing a word to offset 0x1C clears each pending bit whose position is 1 in the word. A fault taken in the same cycle keeps its bit set.
- R6: A taken fault puts the unit in held mode, so the control word reads 0x7. `blocked_o` is 1 whenever a bit is pending or the mode is held. Clearing the faults alone does not release the hold; the run code must be written as well.
- R7: The address of the last taken fault is kept per channel. Page faults go to 0x24. Write multi-hit, write security and write access go to 0x28. Read multi-hit, read security and read access go to 0x2C. Bus errors go to 0x30.
- R8: Offset 0x04 stores only the written bits under mask 0x0150FFFF and drives `cfg_o`. Offset 0x34 reads the 11-bit version in bits [31:21], with the major number in its top 4 bits and the minor number in its low 7 (default 3.3, word 0x30600000).
- R9: A write to the table base (offset 0x14) stores the value and drives `flush_all_o` high for exactly the next cycle. A write with bit 0 set to 0x0C does the same without touching the base. A write with bit 0 set to 0x10 pulses `flush_entry_o` for one cycle, with `flush_addr_o` equal to the written word with its low 12 bits zeroed.
- R10: Reads of unmapped offsets return 0, and writes to the status, pending and version words change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data, combinational from reg_addr |
| flt_valid | input | 1 | Fault event offered |
| flt_ready | output | 1 | Fault event accepted this cycle |
| flt_type | input | 3 | Fault type code, bit position in the pending word |
| flt_addr | input | DATA_W | Faulting address |
| idle_i | input | 1 | Datapath has no transaction outstanding |
| blocked_o | output | 1 | Datapath must stop issuing traffic |
| running_o | output | 1 | Translation active and unblocked |
| irq_o | output | 1 | Fault interrupt |
| cfg_o | output | DATA_W | Masked configuration word |
| tbase_o | output | DATA_W | Page-table base |
| flush_all_o | output | 1 | One-cycle full cache flush request |
| flush_entry_o | output | 1 | One-cycle single-entry flush request |
| flush_addr_o | output | DATA_W | Page address for the entry flush |

## Verification
A register write or a taken fault updates state at the clock edge that samples it, so the new mode, pending bits, captured addresses, `blocked_o` and the flush pulses are all visible in the following cycle. The bench drives at the falling edge and samples at the next falling edge. Reads are combinational and are sampled shortly after the address is driven. The hold acknowledge needs one more edge after `blocked_o` rises: the bench keeps `idle_i` low for several cycles and then raises it, and it expects the status bit exactly one edge later. A flush pulse is checked high in the cycle after its write and low in the cycle after that.

// File: rtl/mmuctl_pkg.sv
package mmuctl_pkg;

  typedef enum logic [1:0] {
    MD_OFF  = 2'd0,
    MD_RUN  = 2'd1,
    MD_HOLD = 2'd2
  } mode_e;

  localparam int CODE_OFF  = 'h0;
  localparam int CODE_RUN  = 'h5;
  localparam int CODE_HOLD = 'h7;

  localparam int NUM_FT  = 8;
  localparam int FT_W    = 3;
  localparam int NUM_CH  = 4;
  localparam int CH_W    = 2;

  localparam logic [FT_W-1:0] FT_PAGE     = 3'd0;
  localparam logic [FT_W-1:0] FT_RD_MULTI = 3'd1;
  localparam logic [FT_W-1:0] FT_WR_MULTI = 3'd2;
  localparam logic [FT_W-1:0] FT_BUS      = 3'd3;
  localparam logic [FT_W-1:0] FT_RD_SEC   = 3'd4;
  localparam logic [FT_W-1:0] FT_RD_ACC   = 3'd5;
  localparam logic [FT_W-1:0] FT_WR_SEC   = 3'd6;
  localparam logic [FT_W-1:0] FT_WR_ACC   = 3'd7;

  localparam logic [CH_W-1:0] CH_PAGE = 2'd0;
  localparam logic [CH_W-1:0] CH_WR   = 2'd1;
  localparam logic [CH_W-1:0] CH_RD   = 2'd2;
  localparam logic [CH_W-1:0] CH_BUS  = 2'd3;

  localparam int OFS_CTRL  = 'h00;
  localparam int OFS_CFG   = 'h04;
  localparam int OFS_STAT  = 'h08;
  localparam int OFS_FLALL = 'h0C;
  localparam int OFS_FLENT = 'h10;
  localparam int OFS_BASE  = 'h14;
  localparam int OFS_PEND  = 'h18;
  localparam int OFS_CLR   = 'h1C;
  localparam int OFS_APAGE = 'h24;
  localparam int OFS_AWR   = 'h28;
  localparam int OFS_ARD   = 'h2C;
  localparam int OFS_ABUS  = 'h30;
  localparam int OFS_VER   = 'h34;

  function automatic logic [CH_W-1:0] chan_of(input logic [FT_W-1:0] t);
    logic [CH_W-1:0] c;
    case (t)
      FT_PAGE:                         c = CH_PAGE;
      FT_BUS:                          c = CH_BUS;
      FT_WR_MULTI, FT_WR_SEC, FT_WR_ACC: c = CH_WR;
      default:                         c = CH_RD;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/mmuctl_mode.sv
module mmuctl_mode
  import mmuctl_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  go_run,
  input  logic  go_hold,
  input  logic  go_off,
  input  logic  fault_take,
  input  logic  pend_nxt,
  input  logic  idle_i,
  output mode_e mode_q,
  output logic  blocked_q,
  output logic  ack_q
);

  mode_e mode_d;
  logic  blocked_d;
  logic  ack_d;

  always_comb begin
    mode_d = mode_q;
    if (fault_take)   mode_d = MD_HOLD;
    else if (go_run)  mode_d = MD_RUN;
    else if (go_hold) mode_d = MD_HOLD;
    else if (go_off)  mode_d = MD_OFF;
  end

  // the hold counts from the next state so status and blocking change together
  assign blocked_d = (mode_d == MD_HOLD) | pend_nxt;
  assign ack_d     = blocked_d & blocked_q & (ack_q | idle_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= MD_OFF;
      blocked_q <= 1'b0;
      ack_q     <= 1'b0;
    end else begin
      mode_q    <= mode_d;
      blocked_q <= blocked_d;
      ack_q     <= ack_d;
    end
  end

  AST_ACK_INSIDE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ack_q |-> blocked_q); // R3
  AST_ACK_AFTER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_q) |-> $past(idle_i)); // R3
  AST_FAULT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    fault_take |=> (mode_q == MD_HOLD) && blocked_q); // R6

endmodule

// File: rtl/mmuctl_fault.sv
module mmuctl_fault
  import mmuctl_pkg::*;
#(
  parameter int DATA_W = 32
)(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  take,
  input  logic [FT_W-1:0]       ftype,
  input  logic [DATA_W-1:0]     faddr,
  input  logic                  clr_we,
  input  logic [NUM_FT-1:0]     clr_mask,
  output logic [NUM_FT-1:0]     pend_q,
  output logic                  pend_nxt,
  output logic [DATA_W-1:0]     addr_q [NUM_CH]
);

  logic [NUM_FT-1:0] set_vec;
  logic [NUM_FT-1:0] clr_vec;
  logic [NUM_FT-1:0] pend_d;
  logic [CH_W-1:0]   tgt_ch;

  assign set_vec  = take   ? (NUM_FT'(1) << ftype) : '0;
  assign clr_vec  = clr_we ? clr_mask : '0;
  // a fault in the same cycle as its clear survives
  assign pend_d   = (pend_q & ~clr_vec) | set_vec;
  assign pend_nxt = |pend_d;
  assign tgt_ch   = chan_of(ftype);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_cap
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                addr_q[ch] <= '0;
      else if (take && (tgt_ch == CH_W'(ch)))    addr_q[ch] <= faddr;
    end
  end

  AST_FAULT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> pend_q[$past(ftype)]); // R4
  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && !take) |=> ((pend_q & $past(clr_mask)) == '0)); // R5
  AST_NO_SPONTANEOUS: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> ((pend_q & ~$past(pend_q)) == '0)); // R4

endmodule

// File: rtl/mmuctl_flush.sv
module mmuctl_flush #(
  parameter int DATA_W = 32
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              base_we,
  input  logic              all_we,
  input  logic              ent_we,
  input  logic [DATA_W-1:0] ent_addr,
  output logic              flush_all_o,
  output logic              flush_entry_o,
  output logic [DATA_W-1:0] flush_addr_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flush_all_o   <= 1'b0;
      flush_entry_o <= 1'b0;
      flush_addr_o  <= '0;
    end else begin
      flush_all_o   <= base_we | all_we;
      flush_entry_o <= ent_we;
      if (ent_we) flush_addr_o <= ent_addr;
    end
  end

  AST_BASE_FLUSHES: assert property (@(posedge clk) disable iff (!rst_n)
    base_we |=> flush_all_o); // R9
  AST_PULSE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_all_o && !$past(base_we | all_we)) |-> 1'b0); // R9

endmodule

// File: rtl/mmuctl_top.sv
module mmuctl_top
  import mmuctl_pkg::*;
#(
  parameter int                ADDR_W     = 8,
  parameter int                DATA_W     = 32,
  parameter int                VER_MAJOR  = 3,
  parameter int                VER_MINOR  = 3,
  parameter logic [DATA_W-1:0] CFG_MASK   = 32'h0150_FFFF,
  parameter int                PAGE_SHIFT = 12
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              flt_valid,
  output logic              flt_ready,
  input  logic [FT_W-1:0]   flt_type,
  input  logic [DATA_W-1:0] flt_addr,
  input  logic              idle_i,
  output logic              blocked_o,
  output logic              running_o,
  output logic              irq_o,
  output logic [DATA_W-1:0] cfg_o,
  output logic [DATA_W-1:0] tbase_o,
  output logic              flush_all_o,
  output logic              flush_entry_o,
  output logic [DATA_W-1:0] flush_addr_o
);

  localparam int VER_LSB = 21;
  localparam int VER_RAW = ((VER_MAJOR & 15) << 7) | (VER_MINOR & 127);
  localparam logic [DATA_W-1:0] VER_WORD  = DATA_W'(VER_RAW) << VER_LSB;
  localparam logic [DATA_W-1:0] PAGE_MASK = ~((DATA_W'(1) << PAGE_SHIFT) - DATA_W'(1));

  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_CFG   = ADDR_W'(OFS_CFG);
  localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(OFS_STAT);
  localparam logic [ADDR_W-1:0] A_FLALL = ADDR_W'(OFS_FLALL);
  localparam logic [ADDR_W-1:0] A_FLENT = ADDR_W'(OFS_FLENT);
  localparam logic [ADDR_W-1:0] A_BASE  = ADDR_W'(OFS_BASE);
  localparam logic [ADDR_W-1:0] A_PEND  = ADDR_W'(OFS_PEND);
  localparam logic [ADDR_W-1:0] A_CLR   = ADDR_W'(OFS_CLR);
  localparam logic [ADDR_W-1:0] A_APAGE = ADDR_W'(OFS_APAGE);
  localparam logic [ADDR_W-1:0] A_AWR   = ADDR_W'(OFS_AWR);
  localparam logic [ADDR_W-1:0] A_ARD   = ADDR_W'(OFS_ARD);
  localparam logic [ADDR_W-1:0] A_ABUS  = ADDR_W'(OFS_ABUS);
  localparam logic [ADDR_W-1:0] A_VER   = ADDR_W'(OFS_VER);

  mode_e             mode_q;
  logic              ack_q;
  logic              pend_nxt;
  logic [NUM_FT-1:0] pend_q;
  logic [DATA_W-1:0] cap_q [NUM_CH];
  logic              take;
  logic              we_ctrl, we_cfg, we_base, we_clr, we_flall, we_flent;
  logic              go_run, go_hold, go_off;
  logic [DATA_W-1:0] cfg_q, base_q;
  logic [DATA_W-1:0] ctrl_rd;

  assign we_ctrl  = reg_we && (reg_addr == A_CTRL);
  assign we_cfg   = reg_we && (reg_addr == A_CFG);
  assign we_base  = reg_we && (reg_addr == A_BASE);
  assign we_clr   = reg_we && (reg_addr == A_CLR);
  assign we_flall = reg_we && (reg_addr == A_FLALL) && reg_wdata[0];
  assign we_flent = reg_we && (reg_addr == A_FLENT) && reg_wdata[0];

  assign go_run  = we_ctrl && (reg_wdata == DATA_W'(CODE_RUN));
  assign go_hold = we_ctrl && (reg_wdata == DATA_W'(CODE_HOLD));
  assign go_off  = we_ctrl && (reg_wdata == DATA_W'(CODE_OFF));

  assign flt_ready = (mode_q != MD_OFF);
  assign take      = flt_valid && flt_ready;

  mmuctl_mode u_mode (
    .clk        (clk),
    .rst_n      (rst_n),
    .go_run     (go_run),
    .go_hold    (go_hold),
    .go_off     (go_off),
    .fault_take (take),
    .pend_nxt   (pend_nxt),
    .idle_i     (idle_i),
    .mode_q     (mode_q),
    .blocked_q  (blocked_o),
    .ack_q      (ack_q)
  );

  mmuctl_fault #(.DATA_W(DATA_W)) u_fault (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (take),
    .ftype    (flt_type),
    .faddr    (flt_addr),
    .clr_we   (we_clr),
    .clr_mask (reg_wdata[NUM_FT-1:0]),
    .pend_q   (pend_q),
    .pend_nxt (pend_nxt),
    .addr_q   (cap_q)
  );

  mmuctl_flush #(.DATA_W(DATA_W)) u_flush (
    .clk           (clk),
    .rst_n         (rst_n),
    .base_we       (we_base),
    .all_we        (we_flall),
    .ent_we        (we_flent),
    .ent_addr      (reg_wdata & PAGE_MASK),
    .flush_all_o   (flush_all_o),
    .flush_entry_o (flush_entry_o),
    .flush_addr_o  (flush_addr_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      base_q <= '0;
    end else begin
      if (we_cfg)  cfg_q  <= reg_wdata & CFG_MASK;
      if (we_base) base_q <= reg_wdata;
    end
  end

  assign cfg_o     = cfg_q;
  assign tbase_o   = base_q;
  assign irq_o     = |pend_q;
  assign running_o = (mode_q == MD_RUN) && !blocked_o;

  always_comb begin
    case (mode_q)
      MD_RUN:  ctrl_rd = DATA_W'(CODE_RUN);
      MD_HOLD: ctrl_rd = DATA_W'(CODE_HOLD);
      default: ctrl_rd = DATA_W'(CODE_OFF);
    endcase
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL:  reg_rdata = ctrl_rd;
      A_CFG:   reg_rdata = cfg_q;
      A_STAT:  reg_rdata = DATA_W'(ack_q);
      A_BASE:  reg_rdata = base_q;
      A_PEND:  reg_rdata = DATA_W'(pend_q);
      A_APAGE: reg_rdata = cap_q[CH_PAGE];
      A_AWR:   reg_rdata = cap_q[CH_WR];
      A_ARD:   reg_rdata = cap_q[CH_RD];
      A_ABUS:  reg_rdata = cap_q[CH_BUS];
      A_VER:   reg_rdata = VER_WORD;
      default: reg_rdata = '0;
    endcase
  end

  AST_IRQ_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> blocked_o); // R6
  AST_OFF_REFUSES: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MD_OFF) |-> !take); // R4
  AST_CFG_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    we_cfg |=> ((cfg_o & ~CFG_MASK) == '0)); // R8

endmodule

// File: tb/mmuctl_top_tb.sv
module mmuctl_top_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        flt_valid = 1'b0;
  logic        flt_ready;
  logic [2:0]  flt_type = '0;
  logic [31:0] flt_addr = '0;
  logic        idle_i = 1'b1;
  logic        blocked_o, running_o, irq_o;
  logic [31:0] cfg_o, tbase_o, flush_addr_o;
  logic        flush_all_o, flush_entry_o;

  int n_chk = 0;
  int n_bad = 0;

  // bench model
  int          m_mode = 0;      // 0 off, 1 run, 2 hold
  logic [7:0]  m_pend = '0;
  logic [31:0] m_cap [4];

  always #(CLK_PERIOD/2) clk = ~clk;

  mmuctl_top u_dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .flt_valid(flt_valid),
    .flt_ready(flt_ready), .flt_type(flt_type), .flt_addr(flt_addr),
    .idle_i(idle_i), .blocked_o(blocked_o), .running_o(running_o),
    .irq_o(irq_o), .cfg_o(cfg_o), .tbase_o(tbase_o),
    .flush_all_o(flush_all_o), .flush_entry_o(flush_entry_o),
    .flush_addr_o(flush_addr_o)
  );

  function automatic int chan_ofs(input logic [2:0] t);
    case (t)
      3'd0:             return 'h24;
      3'd3:             return 'h30;
      3'd2, 3'd6, 3'd7: return 'h28;
      default:          return 'h2C;
    endcase
  endfunction

  function automatic int cap_idx(input int ofs);
    return (ofs - 'h24) / 4;
  endfunction

  function automatic logic [31:0] mode_code(input int m);
    return (m == 1) ? 32'h5 : (m == 2) ? 32'h7 : 32'h0;
  endfunction

  function automatic logic exp_blocked();
    return (m_mode == 2) || (m_pend != 0);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_we = 1'b0;
    #1 d = reg_rdata;
  endtask

  task automatic send_flt(input logic [2:0] t, input logic [31:0] a);
    @(negedge clk);
    flt_valid = 1'b1; flt_type = t; flt_addr = a;
    @(negedge clk);
    flt_valid = 1'b0;
    if (m_mode != 0) begin
      m_pend[t] = 1'b1;
      m_cap[cap_idx(chan_ofs(t))] = a;
      m_mode = 2;
    end
  endtask

  task automatic do_clear(input logic [7:0] m);
    bus_wr(8'h1C, {24'h0, m});
    m_pend = m_pend & ~m;
  endtask

  task automatic do_run();
    bus_wr(8'h00, 32'h5);
    m_mode = 1;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'h1, 32'h0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : stim
    logic [31:0] rd;
    int seed_v;
    seed_v = $urandom(32'h5EED);
    for (int i = 0; i < 4; i++) m_cap[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    bus_rd(8'h00, rd); chk("R1 ctrl", rd, 32'h0);
    bus_rd(8'h08, rd); chk("R1 status", rd, 32'h0);
    bus_rd(8'h18, rd); chk("R1 pending", rd, 32'h0);
    chk("R1 outputs", {27'h0, irq_o, blocked_o, running_o, flt_ready, 1'b0}, 32'h0);

    // R4 fault while disabled is refused
    send_flt(3'd3, 32'hDEAD_0000);
    bus_rd(8'h18, rd); chk("R4 off ignores fault", rd, 32'h0);
    bus_rd(8'h30, rd); chk("R4 off no capture", rd, 32'h0);

    // R2 mode codes
    bus_wr(8'h00, 32'h3);
    bus_rd(8'h00, rd); chk("R2 bad code ignored", rd, 32'h0);
    do_run();
    bus_rd(8'h00, rd); chk("R2 run code", rd, 32'h5);
    chk("R2 running/ready", {30'h0, running_o, flt_ready}, 32'h3);
    bus_wr(8'h00, 32'h105);
    bus_rd(8'h00, rd); chk("R2 upper bits make code invalid", rd, 32'h5);

    // R3 hold handshake
    idle_i = 1'b0;
    bus_wr(8'h00, 32'h7);
    chk("R3 blocked after hold", {31'h0, blocked_o}, 32'h1);
    repeat (3) begin
      bus_rd(8'h08, rd); chk("R3 no ack while busy", rd, 32'h0);
    end
    idle_i = 1'b1;
    bus_rd(8'h08, rd); chk("R3 ack after idle", rd, 32'h1);
    bus_wr(8'h00, 32'h5);
    chk("R3 ack drops with block", {30'h0, blocked_o, 1'b0}, 32'h0);
    bus_rd(8'h08, rd); chk("R3 status cleared", rd, 32'h0);
    m_mode = 1;

    // R8 config and version
    bus_wr(8'h04, 32'hFFFF_FFFF);
    bus_rd(8'h04, rd); chk("R8 cfg mask", rd, 32'h0150_FFFF);
    chk("R8 cfg_o", cfg_o, 32'h0150_FFFF);
    bus_rd(8'h34, rd); chk("R8 version", rd, 32'h3060_0000);

    // R10 unmapped and read-only
    bus_rd(8'h40, rd); chk("R10 unmapped", rd, 32'h0);
    bus_wr(8'h18, 32'hFF); bus_wr(8'h08, 32'h1); bus_wr(8'h34, 32'h0);
    bus_rd(8'h18, rd); chk("R10 pending read-only", rd, 32'h0);
    bus_rd(8'h08, rd); chk("R10 status read-only", rd, 32'h0);
    bus_rd(8'h34, rd); chk("R10 version read-only", rd, 32'h3060_0000);

    // R9 flushes
    bus_wr(8'h14, 32'h8000_4000);
    chk("R9 base flush pulse", {31'h0, flush_all_o}, 32'h1);
    @(negedge clk);
    chk("R9 pulse one cycle", {31'h0, flush_all_o}, 32'h0);
    chk("R9 base value", tbase_o, 32'h8000_4000);
    bus_wr(8'h0C, 32'h0);
    chk("R9 flush bit0 clear no pulse", {31'h0, flush_all_o}, 32'h0);
    bus_wr(8'h0C, 32'h1);
    chk("R9 full flush pulse", {31'h0, flush_all_o}, 32'h1);
    chk("R9 base untouched", tbase_o, 32'h8000_4000);
    bus_wr(8'h10, 32'h1234_5FFF);
    chk("R9 entry pulse", {31'h0, flush_entry_o}, 32'h1);
    chk("R9 entry addr", flush_addr_o, 32'h1234_5000);
    @(negedge clk);
    chk("R9 entry one cycle", {31'h0, flush_entry_o}, 32'h0);

    // R6 fault forces hold
    send_flt(3'd0, 32'hAAAA_1000);
    bus_rd(8'h00, rd); chk("R6 ctrl held", rd, 32'h7);
    chk("R6 irq/blocked", {30'h0, irq_o, blocked_o}, 32'h3);
    bus_rd(8'h24, rd); chk("R7 page addr", rd, 32'hAAAA_1000);
    do_clear(8'h01);
    chk("R6 held after clear", {31'h0, blocked_o}, 32'h1);
    do_run();
    chk("R6 released", {30'h0, blocked_o, running_o}, 32'h1);
    send_flt(3'd6, 32'h0000_BEE0);
    do_run();
    chk("R6 run while pending stays blocked", {30'h0, blocked_o, running_o}, 32'h2);
    bus_rd(8'h28, rd); chk("R7 write addr", rd, 32'h0000_BEE0);

    // R5 same-cycle clear and fault
    @(negedge clk);
    reg_addr = 8'h1C; reg_wdata = 32'h40; reg_we = 1'b1;
    flt_valid = 1'b1; flt_type = 3'd6; flt_addr = 32'h0000_C0DE;
    @(negedge clk);
    reg_we = 1'b0; flt_valid = 1'b0;
    m_cap[1] = 32'h0000_C0DE; m_mode = 2;
    bus_rd(8'h18, rd); chk("R5 fault wins over clear", rd, 32'h40);
    do_clear(8'h40);
    bus_rd(8'h18, rd); chk("R5 clear", rd, 32'h0);
    do_run();

    // random mix against the model
    for (int it = 0; it < 400; it++) begin
      int op;
      op = $urandom_range(0, 3);
      case (op)
        0: send_flt(3'($urandom_range(0, 7)), $urandom);
        1: do_clear(8'($urandom));
        2: do_run();
        default: begin
          bus_rd(8'h18, rd); chk("R4 R5 pending", rd, {24'h0, m_pend});
          chk("R4 irq", {31'h0, irq_o}, {31'h0, |m_pend});
          chk("R6 blocked", {31'h0, blocked_o}, {31'h0, exp_blocked()});
          bus_rd(8'h00, rd); chk("R6 ctrl mode", rd, mode_code(m_mode));
          for (int c = 0; c < 4; c++) begin
            bus_rd(8'(8'h24 + 4*c), rd); chk("R7 capture", rd, m_cap[c]);
          end
        end
      endcase
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule